// File: doc/BRIEF.md
# Integer ALU with Stored Condition Flags

This block performs the four integer operations of a compact byte-coded instruction set on two 32-bit register operands: add, subtract, bitwise AND and bitwise XOR. It holds a three-bit condition register with a zero flag, a sign flag and an overflow flag. It also decides whether a jump or conditional move takes effect, using those stored flags and a 4-bit condition code.

The ALU result is combinational from the operands and the operation code. The condition register loads on a rising clock edge only when the operation strobe is high and the operation code is legal. Condition evaluation always reads the stored flags, never the flags of the operation now in flight. So a compare, followed in the next cycle by a branch decision, sees the compare's outcome. Condition code 0 is the unconditional form and always evaluates true, so unconditional and conditional moves and jumps share one path.

Top module: `alu_cond_top`

## Requirements
- R1: `alu_fn` 0 gives `op_a + op_b`, 2 gives `op_a & op_b` and 3 gives `op_a ^ op_b`, all modulo 2^32, in the same cycle as the inputs.
- R2: `alu_fn` 1 gives `op_b - op_a`: the first operand is subtracted from the second.
- R3: After an edge on which the flags load, the zero flag is 1 exactly when the result was zero, and the sign flag equals bit 31 of the result.
- R4: After a loading edge for add or subtract, the overflow flag is 1 exactly when the signed two's-complement result overflowed.
- R5: After a loading edge for AND or XOR, the overflow flag is 0.
- R6: When `op_valid` is low, the flags hold their value while `result` still shows the operation.
- R7: Reset (`rst_n` low) sets the zero flag to 1 and the sign and overflow flags to 0.
- R8: `cond_true` follows the stored flags, using lt = SF^OF. For `cond_fn` 1 (le) it is lt|ZF; for 2 (l) it is lt; for 3 (e) it is ZF; for 4 (ne) it is !ZF; for 5 (ge) it is !lt; for 6 (g) it is !lt & !ZF.
- R9: `cond_fn` 0 makes `cond_true` 1 whatever the flags hold.
- R10: A `cond_fn` from 7 to 15 makes `cond_true` 0 and raises `cond_fn_bad`. `cond_fn_bad` is 0 for codes 0 to 6.
- R11: An `alu_fn` from 4 to 15 raises `alu_fn_bad` and drives `result` to zero. With such a code the flags do not load, even with `op_valid` high. `alu_fn_bad` is 0 for codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_a | input | 32 | First operand (subtrahend for subtract) |
| op_b | input | 32 | Second operand |
| alu_fn | input | 4 | Operation code: 0 add, 1 sub, 2 and, 3 xor |
| op_valid | input | 1 | Strobe that lets the flags load on this edge |
| cond_fn | input | 4 | Condition code 0 to 6 |
| result | output | 32 | Combinational operation result |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| flag_of | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Selected condition holds on the stored flags |
| alu_fn_bad | output | 1 | Operation code is out of range |
| cond_fn_bad | output | 1 | Condition code is out of range |

## Verification
`result`, `alu_fn_bad` and `cond_fn_bad` are due in the same cycle as the inputs that produce them. The flags are due one rising edge after a valid strobe. `cond_true` follows the flags and so shows a new value in that same later cycle. The driver sets the inputs on the falling edge. It queues the expected result together with the flags that were stored before the coming edge. The monitor compares 5 ns after that falling edge, ahead of the rising edge. A flag update caused by one item is therefore checked with the next item.

// File: rtl/alu_cond_pkg.sv
package alu_cond_pkg;

    typedef enum logic [3:0] {
        FN_ADD = 4'h0,
        FN_SUB = 4'h1,
        FN_AND = 4'h2,
        FN_XOR = 4'h3
    } alu_fn_e;

    typedef enum logic [3:0] {
        CND_ALWAYS = 4'h0,
        CND_LE     = 4'h1,
        CND_LT     = 4'h2,
        CND_EQ     = 4'h3,
        CND_NE     = 4'h4,
        CND_GE     = 4'h5,
        CND_GT     = 4'h6
    } cond_fn_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } ccode_t;

    localparam ccode_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_cond_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       fn,
    output logic [WIDTH-1:0] res,
    output ccode_t           cc_next,
    output logic             fn_bad
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic             ovf;

    assign sum  = b + a;
    assign diff = b - a;

    always_comb begin
        res    = '0;
        ovf    = 1'b0;
        fn_bad = 1'b0;
        unique case (fn)
            FN_ADD: begin
                res = sum;
                ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
            end
            FN_SUB: begin
                res = diff;
                ovf = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);
            end
            FN_AND: res = a & b;
            FN_XOR: res = a ^ b;
            default: fn_bad = 1'b1;
        endcase
    end

    always_comb begin
        cc_next.zf = (res == '0);
        cc_next.sf = res[MSB];
        cc_next.of = ovf;
    end

endmodule

// File: rtl/cc_reg.sv
module cc_reg
    import alu_cond_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  ccode_t d,
    output ccode_t q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CC_RESET;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import alu_cond_pkg::*;
(
    input  ccode_t     cc,
    input  logic [3:0] fn,
    output logic       take,
    output logic       fn_bad
);
    logic lt;

    assign lt = cc.sf ^ cc.of;

    always_comb begin
        take   = 1'b0;
        fn_bad = 1'b0;
        unique case (fn)
            CND_ALWAYS: take = 1'b1;
            CND_LE:     take = lt | cc.zf;
            CND_LT:     take = lt;
            CND_EQ:     take = cc.zf;
            CND_NE:     take = ~cc.zf;
            CND_GE:     take = ~lt;
            CND_GT:     take = ~lt & ~cc.zf;
            default:    fn_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu_cond_top.sv
module alu_cond_top
    import alu_cond_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       alu_fn,
    input  logic             op_valid,
    input  logic [3:0]       cond_fn,
    output logic [WIDTH-1:0] result,
    output logic             flag_zf,
    output logic             flag_sf,
    output logic             flag_of,
    output logic             cond_true,
    output logic             alu_fn_bad,
    output logic             cond_fn_bad
);
    ccode_t cc_next;
    ccode_t cc_q;
    logic   cc_load;

    alu_core #(.WIDTH(WIDTH)) u_core (
        .a       (op_a),
        .b       (op_b),
        .fn      (alu_fn),
        .res     (result),
        .cc_next (cc_next),
        .fn_bad  (alu_fn_bad)
    );

    assign cc_load = op_valid & ~alu_fn_bad;

    cc_reg u_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cc_load),
        .d     (cc_next),
        .q     (cc_q)
    );

    cond_eval u_cond (
        .cc     (cc_q),
        .fn     (cond_fn),
        .take   (cond_true),
        .fn_bad (cond_fn_bad)
    );

    assign flag_zf = cc_q.zf;
    assign flag_sf = cc_q.sf;
    assign flag_of = cc_q.of;

endmodule

// File: rtl/alu_cond_chk.sv
module alu_cond_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       alu_fn,
    input logic             op_valid,
    input logic [3:0]       cond_fn,
    input logic [WIDTH-1:0] result,
    input logic             flag_zf,
    input logic             flag_sf,
    input logic             flag_of,
    input logic             cond_true,
    input logic             alu_fn_bad,
    input logic             cond_fn_bad
);
    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && alu_fn < 4'd4) |=> (flag_zf == ($past(result) == '0)));

    assert_sign_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && alu_fn < 4'd4) |=> (flag_sf == $past(result[WIDTH-1])));

    assert_logic_clears_of_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (alu_fn == 4'd2 || alu_fn == 4'd3)) |=> !flag_of);

    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({flag_zf, flag_sf, flag_of}));

    assert_always_true_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 4'd0) |-> cond_true);

    assert_not_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 4'd4) |-> (cond_true == !flag_zf));

    assert_bad_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn > 4'd6) |-> (!cond_true && cond_fn_bad));

    assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn > 4'd3) |-> (alu_fn_bad && result == '0));

    assert_bad_op_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn > 4'd3) |=> $stable({flag_zf, flag_sf, flag_of}));

    logic unused_ok;
    assign unused_ok = ^{op_a, op_b};

endmodule

bind alu_cond_top alu_cond_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_a        (op_a),
    .op_b        (op_b),
    .alu_fn      (alu_fn),
    .op_valid    (op_valid),
    .cond_fn     (cond_fn),
    .result      (result),
    .flag_zf     (flag_zf),
    .flag_sf     (flag_sf),
    .flag_of     (flag_of),
    .cond_true   (cond_true),
    .alu_fn_bad  (alu_fn_bad),
    .cond_fn_bad (cond_fn_bad)
);

// File: tb/sim_alu_cond_top.sv
`timescale 1ns/1ps
module sim_alu_cond_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  alu_fn = '0;
    logic        op_valid = 1'b0;
    logic [3:0]  cond_fn = '0;
    logic [31:0] result;
    logic        flag_zf, flag_sf, flag_of;
    logic        cond_true, alu_fn_bad, cond_fn_bad;

    always #10 clk = ~clk;

    alu_cond_top u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .alu_fn(alu_fn), .op_valid(op_valid), .cond_fn(cond_fn),
        .result(result), .flag_zf(flag_zf), .flag_sf(flag_sf),
        .flag_of(flag_of), .cond_true(cond_true),
        .alu_fn_bad(alu_fn_bad), .cond_fn_bad(cond_fn_bad)
    );

    typedef struct {
        logic [31:0] res;
        logic [2:0]  flags;
        logic        take;
        logic        abad;
        logic        cbad;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    logic mz = 1'b1, ms = 1'b0, mo = 1'b0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic cond_model(logic [3:0] c, logic z, logic s, logic o);
        logic lt;
        lt = s ^ o;
        case (c)
            4'd0: return 1'b1;
            4'd1: return lt | z;
            4'd2: return lt;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return !lt;
            4'd6: return !lt && !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(logic [31:0] a, logic [31:0] b, logic [3:0] fn,
                         logic v, logic [3:0] cf, string tag);
        item_t it;
        logic [31:0] r;
        logic o;
        @(negedge clk);
        op_a = a; op_b = b; alu_fn = fn; op_valid = v; cond_fn = cf;
        o = 1'b0;
        case (fn)
            4'd0: begin r = a + b; o = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd1: begin r = b - a; o = (a[31] != b[31]) && (r[31] != b[31]); end
            4'd2: r = a & b;
            4'd3: r = a ^ b;
            default: r = '0;
        endcase
        it.res = r;
        it.flags = {mz, ms, mo};
        it.take = cond_model(cf, mz, ms, mo);
        it.abad = (fn > 4'd3);
        it.cbad = (cf > 4'd6);
        it.tag = tag;
        q.push_back(it);
        if (v && fn <= 4'd3) begin
            mz = (r == '0); ms = r[31]; mo = o;
        end
    endtask

    task automatic sweep(string tag);
        for (int c = 0; c < 16; c++) drive(32'd0, 32'd0, 4'd0, 1'b0, 4'(c), tag);
    endtask

    always begin
        item_t it;
        @(negedge clk);
        #5;
        if (q.size() > 0) begin
            it = q.pop_front();
            check(it.tag, "result", result, it.res);
            check(it.tag, "flags zf/sf/of", {29'd0, flag_zf, flag_sf, flag_of}, {29'd0, it.flags});
            check(it.tag, "cond_true", {31'd0, cond_true}, {31'd0, it.take});
            check(it.tag, "alu_fn_bad", {31'd0, alu_fn_bad}, {31'd0, it.abad});
            check(it.tag, "cond_fn_bad", {31'd0, cond_fn_bad}, {31'd0, it.cbad});
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R7: reset values
        check("R7", "reset flags", {29'd0, flag_zf, flag_sf, flag_of}, 32'd4);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: equal holds on reset flags
        drive(32'd0, 32'd0, 4'd0, 1'b0, 4'd3, "R8");
        drive(32'd5, 32'd7, 4'd0, 1'b1, 4'd0, "R1");
        drive(32'd3, 32'd10, 4'd1, 1'b1, 4'd6, "R2");
        drive(32'd10, 32'd3, 4'd1, 1'b1, 4'd2, "R3");
        sweep("R8");
        drive(32'h7fffffff, 32'd1, 4'd0, 1'b1, 4'd0, "R4");
        sweep("R8");
        drive(32'd1, 32'h80000000, 4'd1, 1'b1, 4'd0, "R4");
        drive(32'hf0f0f0f0, 32'h0f0f0f0f, 4'd2, 1'b1, 4'd3, "R5");
        drive(32'h12345678, 32'hff00ff00, 4'd3, 1'b1, 4'd0, "R1");
        drive(32'h80000000, 32'h80000000, 4'd0, 1'b1, 4'd0, "R4");
        drive(32'hc0ffee00, 32'h0000beef, 4'd3, 1'b1, 4'd5, "R5");
        drive(32'd42, 32'd42, 4'd1, 1'b1, 4'd3, "R3");
        sweep("R8");
        drive(32'd1, 32'd1, 4'd0, 1'b0, 4'd3, "R6");
        drive(32'hffffffff, 32'd0, 4'd1, 1'b0, 4'd4, "R6");
        drive(32'd9, 32'd9, 4'd5, 1'b1, 4'd0, "R11");
        drive(32'd9, 32'd8, 4'd15, 1'b1, 4'd3, "R11");
        drive(32'd5, 32'd2, 4'd1, 1'b1, 4'd7, "R10");
        sweep("R8");
        drive(32'd0, 32'd0, 4'd0, 1'b0, 4'd15, "R10");
        drive(32'd0, 32'd0, 4'd0, 1'b0, 4'd0, "R9");
        repeat (3) @(negedge clk);
        #8;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule